// File: doc/BRIEF.md
# 64B/66B Receive Gearbox with Bit Slip

This block sits between a receive deserializer and the block-lock logic of a 64B/66B link. Each clock it accepts one word of raw received bits, with the first-received bit in bit 0. It cuts that stream into blocks, each a sync header followed by 64 payload bits. The header leaves on a 3-bit header output and the payload on a 32-bit data output, each with its own valid flag. A 64B/67B mode uses a 3-bit header instead of 2 bits. A 2-byte path takes 16 bits per clock on the low half of the input and returns 16-bit payload pieces on the low half of the output.

Input and output share one clock. The header bits take input bandwidth that produces no payload, so the data-valid flag drops on a fixed share of cycles. The block never finds block boundaries by itself. External lock logic watches the headers and raises the slip input, and each rising edge of slip discards one received bit. That moves the extraction point one bit later in the stream. A slip takes a fixed number of clocks to act, and both valid flags stay low while it is pending.

The mode inputs `hdr3_mode` and `half_lane` are static and may change only while reset is asserted.

Top module: `rx_block_gearbox`

## Requirements
- R1: With `hdr3_mode` low, each block is a 2-bit header followed by 64 payload bits. The header appears on `blk_hdr[1:0]`, with the first-received bit in bit 0, and `blk_hdr[2]` is 0.
- R2: With `hdr3_mode` high, each block is a 3-bit header followed by 64 payload bits, and the header appears on `blk_hdr[2:0]` with the first-received bit in bit 0.
- R3: On the 4-byte path the 64 payload bits leave as two consecutive valid 32-bit words, the earlier-received half first, with the first-received bit in bit 0. `hdr_valid` is high only together with `pay_valid` on the first of those words.
- R4: On the 4-byte path, once the block is running steadily, `pay_valid` is low for exactly one isolated cycle every 33 cycles in 64B/66B mode, and on 3 of every 67 cycles in 64B/67B mode.
- R5: On the 2-byte path, input bits come from `rx_word[15:0]` and payload leaves on `pay_data[15:0]` as four valid 16-bit pieces per block, earliest first. `pay_data[31:16]` is 0. In 64B/66B mode `pay_valid` drops for two consecutive cycles after every 64 valid cycles (period 66), and in 64B/67B mode it is low on 6 of every 134 cycles.
- R6: Each accepted rising edge of `slip_req` discards exactly one received bit. A stream whose first block starts k bits late is extracted correctly after k accepted slips.
- R7: On the 4-byte path, after a rising edge of `slip_req` is sampled at clock edge t, both valid flags are low after clock edges t+2 through t+5 (a 4-clock slip latency plus one output register).
- R8: Holding `slip_req` high causes only one slip, and a rising edge that arrives while an earlier slip is still pending is ignored.
- R9: While `rst_n` is low, all outputs are 0. Reset empties the bit buffer. The first valid output, a block's first word with its header, appears after the third clock edge following reset release on the 4-byte path and after the fifth on the 2-byte path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for input and output |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr3_mode | input | 1 | 1 selects 3-bit headers (64B/67B), 0 selects 2-bit headers |
| half_lane | input | 1 | 1 selects the 2-byte path, 0 the 4-byte path |
| rx_word | input | 32 | Received bits, first-received in bit 0 |
| slip_req | input | 1 | Rising edge requests a one-bit slip |
| pay_data | output | 32 | Payload word or 16-bit piece |
| pay_valid | output | 1 | `pay_data` carries payload this cycle |
| blk_hdr | output | 3 | Block header, valid with `hdr_valid` |
| hdr_valid | output | 1 | `blk_hdr` is new and `pay_data` is the block's first piece |

## Verification
The assertions check on every cycle that a header never comes without data, that `blk_hdr[2]` is zero in 2-bit header mode and the upper payload half is zero on the 2-byte path, and that a 2-byte header piece is always followed by its second piece. They also check that a pending slip forces both valid flags low, that a held slip never starts a new window, and that the bit buffer stays within bounds. Only the bench scenarios can show that payload words come out in stream order with the right headers. The same holds for the count and spacing of invalid cycles in each mode, for k slips bringing a k-bit-late stream into lock, and for the first valid cycle after reset.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

    localparam int HDR66_W = 2;
    localparam int HDR67_W = 3;

    typedef enum logic {
        ALIGN_HDR  = 1'b0,
        ALIGN_TAIL = 1'b1
    } blk_phase_e;

endpackage

// File: rtl/gbx_lane_pack.sv
module gbx_lane_pack #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_lane_i,
    input  logic [WORD_W-1:0] din_i,
    output logic              strobe_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int HALF_W = WORD_W / 2;

    typedef struct packed {
        logic              phase;
        logic [HALF_W-1:0] hold;
    } pack_st_t;

    pack_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        strobe_o = 1'b0;
        word_o   = '0;
        if (!half_lane_i) begin
            strobe_o   = 1'b1;
            word_o     = din_i;
            st_d.phase = 1'b0;
        end else if (!st_q.phase) begin
            st_d.hold  = din_i[HALF_W-1:0];
            st_d.phase = 1'b1;
        end else begin
            strobe_o   = 1'b1;
            word_o     = {din_i[HALF_W-1:0], st_q.hold};
            st_d.phase = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // 2-byte path gives a full word only every other clock
    assert_half_strobe_alt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (half_lane_i && strobe_o) |=> !strobe_o);

endmodule

// File: rtl/gbx_bit_core.sv
module gbx_bit_core
    import gbx_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int SLIP_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              hdr3_i,
    input  logic              slip_i,
    output logic              vld_o,
    output logic              hvld_o,
    output logic [WORD_W-1:0] data_o,
    output logic [2:0]        hdr_o
);
    localparam int BUF_W   = 2 * WORD_W + 8;
    localparam int CNT_W   = $clog2(BUF_W + 1);
    localparam int LAT_W   = $clog2(SLIP_LAT + 1);
    localparam int NEED66  = HDR66_W + WORD_W;
    localparam int NEED67  = HDR67_W + WORD_W;

    typedef struct packed {
        logic [BUF_W-1:0]  bits;
        logic [CNT_W-1:0]  fill;
        blk_phase_e        phase;
        logic [LAT_W-1:0]  lat;
        logic              slip_prev;
        logic              vld;
        logic              hvld;
        logic [WORD_W-1:0] data;
        logic [2:0]        hdr;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [BUF_W-1:0] ext;
    logic [CNT_W-1:0] avail;
    logic             slip_edge;
    logic             quiet;

    always_comb begin
        st_d           = st_q;
        st_d.slip_prev = slip_i;
        st_d.vld       = 1'b0;
        st_d.hvld      = 1'b0;
        slip_edge      = slip_i && !st_q.slip_prev;
        quiet          = (st_q.lat != '0);
        ext            = st_q.bits;
        avail          = st_q.fill;

        if (quiet) begin
            if (st_q.lat > LAT_W'(1)) st_d.lat = st_q.lat - LAT_W'(1);
        end else if (slip_edge) begin
            st_d.lat = LAT_W'(SLIP_LAT);
        end

        if (strobe_i) begin
            ext   = st_q.bits | (BUF_W'(word_i) << st_q.fill);
            avail = st_q.fill + CNT_W'(WORD_W);
            if (st_q.lat == LAT_W'(1)) begin
                ext      = ext >> 1;
                avail    = avail - CNT_W'(1);
                st_d.lat = '0;
            end
            if (st_q.phase == ALIGN_HDR) begin
                if (hdr3_i && avail >= CNT_W'(NEED67)) begin
                    st_d.hdr   = ext[2:0];
                    st_d.data  = ext[HDR67_W +: WORD_W];
                    ext        = ext >> NEED67;
                    avail      = avail - CNT_W'(NEED67);
                    st_d.phase = ALIGN_TAIL;
                    st_d.vld   = !quiet;
                    st_d.hvld  = !quiet;
                end else if (!hdr3_i && avail >= CNT_W'(NEED66)) begin
                    st_d.hdr   = {1'b0, ext[1:0]};
                    st_d.data  = ext[HDR66_W +: WORD_W];
                    ext        = ext >> NEED66;
                    avail      = avail - CNT_W'(NEED66);
                    st_d.phase = ALIGN_TAIL;
                    st_d.vld   = !quiet;
                    st_d.hvld  = !quiet;
                end
            end else if (avail >= CNT_W'(WORD_W)) begin
                st_d.data  = ext[WORD_W-1:0];
                ext        = ext >> WORD_W;
                avail      = avail - CNT_W'(WORD_W);
                st_d.phase = ALIGN_HDR;
                st_d.vld   = !quiet;
            end
        end

        st_d.bits = ext;
        st_d.fill = avail;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign hvld_o = st_q.hvld;
    assign data_o = st_q.data;
    assign hdr_o  = st_q.hdr;

    assert_quiet_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lat != '0) |=> (!st_q.vld && !st_q.hvld));

    assert_edge_arms_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_i && !st_q.slip_prev && st_q.lat == '0) |=> (st_q.lat == LAT_W'(SLIP_LAT)));

    assert_held_no_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_i && st_q.slip_prev && st_q.lat == '0) |=> (st_q.lat == '0));

    assert_fill_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill <= CNT_W'(NEED67 + WORD_W));

endmodule

// File: rtl/gbx_lane_unpack.sv
module gbx_lane_unpack #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_lane_i,
    input  logic              vld_i,
    input  logic              hvld_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic [2:0]        hdr_i,
    output logic              dv_o,
    output logic              hv_o,
    output logic [WORD_W-1:0] data_o,
    output logic [2:0]        hdr_o
);
    localparam int HALF_W = WORD_W / 2;

    typedef struct packed {
        logic              dv;
        logic              hv;
        logic [WORD_W-1:0] data;
        logic [2:0]        hdr;
        logic              pend;
        logic [HALF_W-1:0] upper;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.dv = 1'b0;
        st_d.hv = 1'b0;
        if (!half_lane_i) begin
            st_d.pend = 1'b0;
            if (vld_i) begin
                st_d.dv   = 1'b1;
                st_d.hv   = hvld_i;
                st_d.data = data_i;
                if (hvld_i) st_d.hdr = hdr_i;
            end
        end else if (vld_i) begin
            st_d.dv    = 1'b1;
            st_d.hv    = hvld_i;
            st_d.data  = {{HALF_W{1'b0}}, data_i[HALF_W-1:0]};
            st_d.upper = data_i[WORD_W-1:HALF_W];
            st_d.pend  = 1'b1;
            if (hvld_i) st_d.hdr = hdr_i;
        end else if (st_q.pend) begin
            st_d.dv   = 1'b1;
            st_d.data = {{HALF_W{1'b0}}, st_q.upper};
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dv_o   = st_q.dv;
    assign hv_o   = st_q.hv;
    assign data_o = st_q.data;
    assign hdr_o  = st_q.hdr;

    assert_hdr_needs_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hv_o |-> dv_o);

    assert_half_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (half_lane_i && dv_o) |-> (data_o[WORD_W-1:HALF_W] == '0));

    assert_half_second_piece_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (half_lane_i && hv_o) |=> (dv_o && !hv_o));

endmodule

// File: rtl/rx_block_gearbox.sv
module rx_block_gearbox #(
    parameter int WORD_W   = 32,
    parameter int SLIP_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr3_mode,
    input  logic              half_lane,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              slip_req,
    output logic [WORD_W-1:0] pay_data,
    output logic              pay_valid,
    output logic [2:0]        blk_hdr,
    output logic              hdr_valid
);
    logic              strobe;
    logic [WORD_W-1:0] packed_word;
    logic              core_vld;
    logic              core_hvld;
    logic [WORD_W-1:0] core_data;
    logic [2:0]        core_hdr;

    gbx_lane_pack #(.WORD_W(WORD_W)) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .half_lane_i (half_lane),
        .din_i       (rx_word),
        .strobe_o    (strobe),
        .word_o      (packed_word)
    );

    gbx_bit_core #(.WORD_W(WORD_W), .SLIP_LAT(SLIP_LAT)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe),
        .word_i   (packed_word),
        .hdr3_i   (hdr3_mode),
        .slip_i   (slip_req),
        .vld_o    (core_vld),
        .hvld_o   (core_hvld),
        .data_o   (core_data),
        .hdr_o    (core_hdr)
    );

    gbx_lane_unpack #(.WORD_W(WORD_W)) u_unpack (
        .clk         (clk),
        .rst_n       (rst_n),
        .half_lane_i (half_lane),
        .vld_i       (core_vld),
        .hvld_i      (core_hvld),
        .data_i      (core_data),
        .hdr_i       (core_hdr),
        .dv_o        (pay_valid),
        .hv_o        (hdr_valid),
        .data_o      (pay_data),
        .hdr_o       (blk_hdr)
    );

    assert_hdr66_msb_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr3_mode) |-> (blk_hdr[2] == 1'b0));

endmodule

// File: tb/rx_block_gearbox_test.sv
`timescale 1ns/1ps
module rx_block_gearbox_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr3_mode = 1'b0;
    logic        half_lane = 1'b0;
    logic [31:0] rx_word = '0;
    logic        slip_req = 1'b0;
    logic [31:0] pay_data;
    logic        pay_valid;
    logic [2:0]  blk_hdr;
    logic        hdr_valid;

    always #10 clk = ~clk;

    rx_block_gearbox uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr3_mode (hdr3_mode),
        .half_lane (half_lane),
        .rx_word   (rx_word),
        .slip_req  (slip_req),
        .pay_data  (pay_data),
        .pay_valid (pay_valid),
        .blk_hdr   (blk_hdr),
        .hdr_valid (hdr_valid)
    );

    // {m67, narrow, offset, window, invalid count, invalid-run spacing}
    localparam logic [27:0] SCN [6] = '{
        {1'b0, 1'b0, 7'd0,  8'd132, 4'd4, 7'd33},
        {1'b0, 1'b0, 7'd5,  8'd132, 4'd4, 7'd33},
        {1'b1, 1'b0, 7'd3,  8'd134, 4'd6, 7'd0},
        {1'b0, 1'b1, 7'd7,  8'd132, 4'd4, 7'd66},
        {1'b1, 1'b1, 7'd2,  8'd134, 4'd6, 7'd0},
        {1'b0, 1'b0, 7'd40, 8'd66,  4'd2, 7'd33}
    };

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    int    pos = 0;
    int    cur_off = 0;
    bit    chk_en = 1'b0;
    bit    win_en = 1'b0;
    int    inv_cnt = 0;
    int    tick_no = 0;
    int    last_inv_start = -1;
    int    gap_exp = 0;
    bit    prev_dv = 1'b0;
    bit    have_blk = 1'b0;
    logic [15:0] last_blk = '0;
    int    piece = 0;
    int    hv_seen = 0;
    string seq_tag = "R6";

    function automatic logic stream_bit(int i);
        int bl, hl, j, b, p;
        logic [31:0] bv;
        logic [2:0]  h;
        logic [63:0] pay;
        if (i < cur_off) return logic'(i[0]);
        bl  = hdr3_mode ? 67 : 66;
        hl  = hdr3_mode ? 3 : 2;
        j   = i - cur_off;
        b   = j / bl;
        p   = j % bl;
        bv  = b;
        h   = hdr3_mode ? 3'b101 : 3'b001;
        if (p < hl) return h[p];
        pay = {~bv[15:0], 16'h3C3C, 16'hA55A, bv[15:0]};
        return pay[p - hl];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive();
        int w;
        rx_word = '0;
        if (rst_n) begin
            w = half_lane ? 16 : 32;
            for (int k = 0; k < w; k++) rx_word[k] = stream_bit(pos + k);
            pos += w;
        end
    endtask

    task automatic observe();
        logic [31:0] exp_piece;
        if (chk_en) begin
            if (hdr_valid)
                check(pay_valid == 1'b1, "R3", "header without data", {31'd0, pay_valid}, 32'd1);
            if (pay_valid && hdr_valid) begin
                check(blk_hdr == (hdr3_mode ? 3'b101 : 3'b001), hdr3_mode ? "R2" : "R1",
                      "header value", {29'd0, blk_hdr}, {29'd0, (hdr3_mode ? 3'b101 : 3'b001)});
                if (have_blk)
                    check(pay_data[15:0] == 16'(last_blk + 16'd1), seq_tag, "block order",
                          {16'd0, pay_data[15:0]}, {16'd0, 16'(last_blk + 16'd1)});
                if (half_lane)
                    check(pay_data[31:16] == 16'd0, "R5", "upper half", pay_data, {16'd0, pay_data[15:0]});
                else
                    check(pay_data[31:16] == 16'hA55A, "R3", "first word", pay_data, {16'hA55A, pay_data[15:0]});
                last_blk = pay_data[15:0];
                have_blk = 1'b1;
                piece    = 0;
                hv_seen++;
            end else if (pay_valid && have_blk) begin
                piece++;
                exp_piece = 32'hFFFF_FFFF;
                if (!half_lane) begin
                    if (piece == 1) exp_piece = {~last_blk, 16'h3C3C};
                end else begin
                    if (piece == 1) exp_piece = 32'h0000_A55A;
                    else if (piece == 2) exp_piece = 32'h0000_3C3C;
                    else if (piece == 3) exp_piece = {16'd0, ~last_blk};
                end
                check(pay_data == exp_piece, half_lane ? "R5" : "R3", "payload piece", pay_data, exp_piece);
            end
            if (win_en) begin
                if (!pay_valid) inv_cnt++;
                if (gap_exp != 0 && !pay_valid && prev_dv) begin
                    if (last_inv_start >= 0)
                        check(tick_no - last_inv_start == gap_exp, half_lane ? "R5" : "R4",
                              "invalid spacing", 32'(tick_no - last_inv_start), 32'(gap_exp));
                    last_inv_start = tick_no;
                end
            end
        end
        prev_dv = pay_valid;
        tick_no++;
    endtask

    task automatic tick(input bit s);
        @(negedge clk);
        observe();
        slip_req = s;
        drive();
    endtask

    task automatic prep(input bit m67, input bit narrow, input int off);
        int first;
        @(negedge clk);
        rst_n     = 1'b0;
        slip_req  = 1'b0;
        hdr3_mode = m67;
        half_lane = narrow;
        cur_off   = off;
        pos       = 0;
        chk_en    = 1'b0;
        win_en    = 1'b0;
        seq_tag   = "R6";
        rx_word   = '0;
        repeat (3) begin
            @(negedge clk);
            check(!pay_valid && !hdr_valid && pay_data == 32'd0 && blk_hdr == 3'd0, "R9",
                  "outputs in reset", {pay_valid, hdr_valid, blk_hdr, pay_data[26:0]}, 32'd0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        drive();
        first = narrow ? 5 : 3;
        for (int i = 1; i <= first; i++) begin
            tick(1'b0);
            if (i < first)
                check(!pay_valid, "R9", "early valid after reset", {31'd0, pay_valid}, 32'd0);
            else
                check(pay_valid && hdr_valid, "R9", "first valid after reset",
                      {30'd0, pay_valid, hdr_valid}, 32'd3);
        end
    endtask

    task automatic verify(input int win, input int exp_inv, input int gap, input string tag);
        chk_en = 1'b0;
        repeat (150) tick(1'b0);
        seq_tag        = tag;
        have_blk       = 1'b0;
        hv_seen        = 0;
        last_inv_start = -1;
        gap_exp        = gap;
        inv_cnt        = 0;
        chk_en         = 1'b1;
        win_en         = 1'b1;
        repeat (win) tick(1'b0);
        win_en = 1'b0;
        check(inv_cnt == exp_inv, half_lane ? "R5" : "R4", "invalid cycles in window",
              32'(inv_cnt), 32'(exp_inv));
        repeat (200) tick(1'b0);
        chk_en = 1'b0;
        check(hv_seen > 0, tag, "blocks seen after lock", 32'(hv_seen), 32'd1);
        seq_tag = "R6";
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R9 actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // table walk: modes, offsets resolved by slips (R6), rate (R4, R5)
        for (int s = 0; s < 6; s++) begin
            prep(SCN[s][27], SCN[s][26], int'(SCN[s][25:19]));
            repeat (20) tick(1'b0);
            for (int k = 0; k < int'(SCN[s][25:19]); k++) begin
                tick(1'b1);
                repeat (9) tick(1'b0);
            end
            verify(int'(SCN[s][18:11]), int'(SCN[s][10:7]), int'(SCN[s][6:0]), "R6");
        end

        // R7: latency window with both flags low, then lock
        prep(1'b0, 1'b0, 1);
        repeat (100) tick(1'b0);
        tick(1'b1);
        for (int i = 1; i <= 6; i++) begin
            tick(1'b0);
            if (i >= 3)
                check(!pay_valid && !hdr_valid, "R7", "valid during slip latency",
                      {30'd0, pay_valid, hdr_valid}, 32'd0);
        end
        verify(132, 4, 33, "R6");

        // R8: slip held high for many cycles slips once
        prep(1'b0, 1'b0, 1);
        repeat (50) tick(1'b0);
        repeat (40) tick(1'b1);
        tick(1'b0);
        verify(132, 4, 33, "R8");

        // R8: second rising edge inside the pending window is ignored
        prep(1'b0, 1'b0, 1);
        repeat (50) tick(1'b0);
        tick(1'b1);
        tick(1'b0);
        tick(1'b1);
        repeat (10) tick(1'b0);
        verify(132, 4, 33, "R8");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule